// File: doc/BRIEF.md
# Share-Protected Population Count Accumulator

The block counts the set bits of a long bit vector that is never present in the clear. The vector arrives one 32-bit word per cycle, split into three Boolean shares whose XOR is the true word. Each bit lane turns its three Boolean shares into a pair of additive shares modulo 64. One share is a fresh random value taken from an input port, and the other is the bit minus that value. The two shares go into a pair of 6-bit counters that belong to that lane, so a word's weight never appears unmasked.

A `start` pulse clears all 32 counter pairs and opens a run. Words marked by `word_valid` are accumulated until the word flagged with `last`. The cycle after that word, the block adds up the first-share counters and the second-share counters, combines the two sums modulo 64, and presents the total on `weight` with a one-cycle `done` pulse. The `is_zero` flag reports an all-zero total, which lets a decoder test a shared syndrome for zero by feeding the syndrome's three shares through the same path. The expected total weight stays below 64, for example at most 45, so the modulo-64 result is the exact count.

Top module: `masked_hw_accum`

## Requirements
- R1: After reset, `done` is 0, `weight` is 0 and `is_zero` is 0.
- R2: Words presented with `word_valid` high while no run is open are ignored. This covers words before the first `start` and words after the final word of a run. Such words leave the next result unchanged, raise no `done` and leave the held `weight` unchanged.
- R3: In every lane, the bit `share1[i]^share2[i]^share3[i]` is split into A1 = `rnd[6*i+5:6*i]` and A2 = (bit − A1) mod 64, so that (A1 + A2) mod 64 equals the bit.
- R4: `weight` equals the population count of `share1^share2^share3`, summed over all accepted words of the run and taken modulo 64.
- R5: Cycles with `word_valid` low contribute nothing, whatever the share, `rnd` and `last` inputs carry.
- R6: The final word is sampled at clock edge N. `done` is high for exactly one cycle, from edge N+1, and `weight` and `is_zero` take the new result at that same edge.
- R7: `weight` and `is_zero` hold their values until the next result is produced.
- R8: `is_zero` is 1 exactly when the produced `weight` is 0. An all-zero vector gives `is_zero` = 1.
- R9: The result does not depend on the values on `rnd`.
- R10: A `start` during an open run discards all words accumulated so far and begins a new run.
- R11: A word presented in the same cycle as `start` is not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the counters and opens a run |
| word_valid | input | 1 | A share word is presented this cycle |
| last | input | 1 | The presented word is the final one of the run |
| share1 | input | 32 | First Boolean share of the word |
| share2 | input | 32 | Second Boolean share of the word |
| share3 | input | 32 | Third Boolean share of the word |
| rnd | input | 192 | Fresh 6-bit random value per lane, lane i in bits 6i+5..6i |
| done | output | 1 | One-cycle pulse when a result is ready |
| weight | output | 6 | Total weight modulo 64 |
| is_zero | output | 1 | The produced weight is zero |

## Verification
There is one latency to respect. `done`, `weight` and `is_zero` change at the edge after the one that samples the final word. Counters update at the same edge that samples a word. The bench drives on falling edges. One falling edge after the final word it expects `done` still low. It checks the result on the following falling edge, and one edge later it expects `done` low again with the result unchanged. Ignored stimulus is followed by a completed run, or by a wait of several cycles, before the outputs are compared.

// File: rtl/mhw_pkg.sv
package mhw_pkg;

  localparam int unsigned MHW_LANES = 32;
  localparam int unsigned MHW_CW    = 6;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACC  = 2'd1,
    PH_FIN  = 2'd2
  } mhw_phase_e;

endpackage

// File: rtl/mhw_lane_pair.sv
module mhw_lane_pair #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic          x1,
  input  logic          x2,
  input  logic          x3,
  input  logic [CW-1:0] r_in,
  output logic [CW-1:0] c1,
  output logic [CW-1:0] c2
);

  localparam logic [CW-1:0] ONE = CW'(1);

  // A2 = x - r with x = (x1^x2)^x3, written with b^m = m + b*(1-2m)
  // so that the XOR of all three shares is never formed.
  function automatic logic [CW-1:0] second_share(
    input logic x1_f, input logic x2_f, input logic x3_f,
    input logic [CW-1:0] r_f);
    logic [CW-1:0] t;
    t = {{(CW-1){1'b0}}, x3_f} - r_f;
    if (x1_f ^ x2_f) t = x3_f ? (t - ONE) : (t + ONE);
    return t;
  endfunction

  logic [CW-1:0] a1;
  logic [CW-1:0] a2;
  logic [CW-1:0] share_sum;

  assign a1 = r_in;
  assign a2 = second_share(x1, x2, x3, r_in);
  assign share_sum = a1 + a2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0;
      c2 <= '0;
    end else if (clr) begin
      c1 <= '0;
      c2 <= '0;
    end else if (add) begin
      c1 <= c1 + a1;
      c2 <= c2 + a2;
    end
  end

  // R3
  conv_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    share_sum == {{(CW-1){1'b0}}, (x1 ^ x2 ^ x3)});

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add) |=> ($stable(c1) && $stable(c2)));

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (c1 == '0 && c2 == '0));

endmodule

// File: rtl/mhw_share_sum.sv
module mhw_share_sum #(
  parameter int unsigned LANES = 32,
  parameter int unsigned CW    = 6
) (
  input  logic [LANES*CW-1:0] c1_flat,
  input  logic [LANES*CW-1:0] c2_flat,
  output logic [CW-1:0]       total
);

  logic [CW-1:0] sum1;
  logic [CW-1:0] sum2;

  always_comb begin
    sum1 = '0;
    sum2 = '0;
    for (int i = 0; i < LANES; i++) begin
      sum1 = sum1 + c1_flat[i*CW +: CW];
      sum2 = sum2 + c2_flat[i*CW +: CW];
    end
  end

  assign total = sum1 + sum2;

endmodule

// File: rtl/masked_hw_accum.sv
module masked_hw_accum
  import mhw_pkg::*;
#(
  parameter int unsigned LANES = MHW_LANES,
  parameter int unsigned CW    = MHW_CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                word_valid,
  input  logic                last,
  input  logic [LANES-1:0]    share1,
  input  logic [LANES-1:0]    share2,
  input  logic [LANES-1:0]    share3,
  input  logic [LANES*CW-1:0] rnd,
  output logic                done,
  output logic [CW-1:0]       weight,
  output logic                is_zero
);

  localparam int unsigned FLATW = LANES * CW;

  mhw_phase_e        phase;
  logic              accept;
  logic              final_word;
  logic [FLATW-1:0]  c1_flat;
  logic [FLATW-1:0]  c2_flat;
  logic [CW-1:0]     total;

  assign accept     = word_valid && (phase == PH_ACC) && !start;
  assign final_word = accept && last;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mhw_lane_pair #(.CW(CW)) lane_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .add   (accept),
      .x1    (share1[g]),
      .x2    (share2[g]),
      .x3    (share3[g]),
      .r_in  (rnd[g*CW +: CW]),
      .c1    (c1_flat[g*CW +: CW]),
      .c2    (c2_flat[g*CW +: CW])
    );
  end

  mhw_share_sum #(.LANES(LANES), .CW(CW)) sum_i (
    .c1_flat (c1_flat),
    .c2_flat (c2_flat),
    .total   (total)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      done    <= 1'b0;
      weight  <= '0;
      is_zero <= 1'b0;
    end else if (start) begin
      phase <= PH_ACC;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_ACC:  if (final_word) phase <= PH_FIN;
        PH_FIN: begin
          phase   <= PH_IDLE;
          done    <= 1'b1;
          weight  <= total;
          is_zero <= (total == '0);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (final_word && !start) |=> (!done ##1 (done || $past(start))));

  // R2
  done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(weight) && $stable(is_zero)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (is_zero == (weight == '0)));

endmodule

// File: tb/masked_hw_accum_tb_top.sv
module masked_hw_accum_tb_top;

  localparam int LANES = 32;
  localparam int CW    = 6;

  typedef struct packed {
    int nw;
    int mode;
    int gap;
    int seed;
    int rmode;
  } vec_t;

  // mode: 0 zero, 1 sparse, 2 all ones, 3 dense; rmode: 0 random, 1 zeros, 2 ones
  localparam vec_t TBL [7] = '{
    '{150, 0, 0, 101, 0},
    '{150, 1, 0, 202, 0},
    '{5,   2, 0, 7,   1},
    '{1,   3, 0, 303, 2},
    '{150, 1, 1, 404, 0},
    '{40,  3, 0, 505, 0},
    '{2,   2, 1, 9,   2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic word_valid = 1'b0;
  logic last = 1'b0;
  logic [LANES-1:0] share1 = '0;
  logic [LANES-1:0] share2 = '0;
  logic [LANES-1:0] share3 = '0;
  logic [LANES*CW-1:0] rnd = '0;
  logic done;
  logic [CW-1:0] weight;
  logic is_zero;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] rs = 32'h1;

  always #10 clk = ~clk;

  masked_hw_accum dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
    .last(last), .share1(share1), .share2(share2), .share3(share3),
    .rnd(rnd), .done(done), .weight(weight), .is_zero(is_zero)
  );

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic nxt(output logic [31:0] v);
    rs = xs(rs);
    v = rs;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] d, input int rmode, input bit lst);
    logic [31:0] a, b;
    nxt(a); nxt(b);
    share1 = a; share2 = b; share3 = d ^ a ^ b;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] r;
      nxt(r);
      rnd[k*32 +: 32] = (rmode == 1) ? 32'h0 : (rmode == 2) ? 32'hFFFF_FFFF : r;
    end
    word_valid = 1'b1;
    last = lst;
  endtask

  task automatic run_vec(input vec_t v, output int expw);
    logic [31:0] p, q, s, d;
    rs = v.seed[31:0];
    expw = 0;
    @(negedge clk); start = 1'b1; word_valid = 1'b0;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < v.nw; i++) begin
      nxt(p); nxt(q); nxt(s);
      case (v.mode)
        0: d = 32'h0;
        1: d = p & q & s;
        2: d = 32'hFFFF_FFFF;
        default: d = p;
      endcase
      put_word(d, v.rmode, i == v.nw - 1);
      expw += $countones(d);
      @(negedge clk);
      if (v.gap != 0 && i < v.nw - 1) begin
        // R5: idle cycle carrying ones and last, must add nothing
        put_word(32'hFFFF_FFFF, 0, 1'b1);
        word_valid = 1'b0;
        @(negedge clk);
      end
    end
    word_valid = 1'b0;
    last = 1'b0;
    expw = expw % 64;
  endtask

  task automatic finish_check(input int expw, input string tag);
    // R6: not yet one falling edge after the final word
    chk(done == 1'b0, {tag, " R6 early"}, int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R6 done"}, int'(done), 1);
    // R4
    chk(int'(weight) == expw, {tag, " R4 weight"}, int'(weight), expw);
    // R8
    chk(is_zero == (expw == 0), {tag, " R8 is_zero"}, int'(is_zero), int'(expw == 0));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 pulse"}, int'(done), 0);
    // R7
    chk(int'(weight) == expw, {tag, " R7 hold"}, int'(weight), expw);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int e, e2, hw;
    repeat (3) @(negedge clk);
    // R1
    chk(done == 1'b0 && weight == '0 && is_zero == 1'b0, "R1 reset",
        int'({done, is_zero, weight}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: words before any start are ignored
    put_word(32'hFFFF_FFFF, 0, 1'b1);
    repeat (4) @(negedge clk);
    word_valid = 1'b0; last = 1'b0;
    chk(done == 1'b0, "R2 no run", int'(done), 0);

    foreach (TBL[i]) begin
      run_vec(TBL[i], e);
      finish_check(e, $sformatf("vec%0d R3", i));
    end

    // R9: same data, opposite randomness
    run_vec('{20, 3, 0, 77, 1}, e);
    finish_check(e, "R9 zeros");
    hw = int'(weight);
    run_vec('{20, 3, 0, 77, 2}, e2);
    finish_check(e2, "R9 ones");
    chk(int'(weight) == hw, "R9 independence", int'(weight), hw);

    // R2: words after the final word are ignored, result held
    put_word(32'hFFFF_FFFF, 0, 1'b1);
    repeat (3) @(negedge clk);
    word_valid = 1'b0; last = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R2 after run done", int'(done), 0);
    chk(int'(weight) == hw, "R2 after run weight", int'(weight), hw);

    // R10 and R11: restart mid-run, with a word in the start cycle
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      put_word(32'hFFFF_FFFF, 0, 1'b0);
      @(negedge clk);
    end
    start = 1'b1;
    put_word(32'hFFFF_FFFF, 0, 1'b1);
    @(negedge clk);
    start = 1'b0;
    put_word(32'h0000_000F, 0, 1'b1);
    @(negedge clk);
    word_valid = 1'b0; last = 1'b0;
    finish_check(4, "R10 R11 restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule